// File: doc/BRIEF.md
# Block Check Character Engine

This block keeps a running longitudinal redundancy check over a block of line characters and applies it at the end of the block. Each character is `CHAR_W` bits wide. The most significant bit is the character's parity bit and the lower `CHAR_W-1` bits are data. Every included character is folded column-wise into an accumulator. A block opens with a start pulse that clears the accumulator. The character that ends the block is flagged by the caller. The strobe that follows the flagged character is the check-character slot.

In transmit the caller sends a zero placeholder into that slot. The block raises a substitute strobe and presents the check character, so that the serializer sends it in place of the placeholder. In receive the character arriving in the slot is compared with the computed value, and any difference sets a sticky error flag. The top bit of the check character is derived in one of four selectable ways. The other bits may be sent complemented. Single characters can be left out of the sum, either on the strobe that carries them or on the strobe after. The `lrc_slot` output tells a neighbouring parity unit when to suspend its check.

Top module: `lrc_engine`

## Requirements
- R1: With `cfg_invert`=0, `lrc_value[CHAR_W-2:0]` equals the bitwise XOR of bits `CHAR_W-2:0` of all characters included since the last block start.
- R2: `cfg_invert`=1 complements `lrc_value[CHAR_W-2:0]`, and in parity-accumulate mode it also complements the top bit.
- R3: `cfg_b8_mode` sets the top bit of `lrc_value` as follows. Code 0 makes it the parity of the lower bits, even when `cfg_odd_par`=0 and odd when `cfg_odd_par`=1, so that the whole character has that parity. Code 1 makes it the XOR of the top bits of the included characters. Code 2 forces it to 0 and code 3 forces it to 1.
- R4: `blk_start` clears the accumulator, the pending slot, the skip flag and `lrc_err` on the next clock edge. A character strobed in the same cycle as `blk_start` is not included.
- R5: A character strobed with `excl_now`=1 is not included.
- R6: A character strobed with `excl_next`=1 causes the next strobed character not to be included.
- R7: A character strobed with `chk_next`=1 is included unless it is excluded. `lrc_slot` then goes high from the following cycle until the next strobe. The character in that slot strobe is not included.
- R8: With `dir_tx`=1, `sub_vld` is high during the slot strobe, in the same cycle, and `lrc_value` carries the check character. `sub_vld` is low on every other cycle and always low when `dir_tx`=0.
- R9: With `dir_tx`=0, a slot strobe whose `chr_data` differs from `lrc_value` in any compared bit sets `lrc_err` from the next cycle. `lrc_err` then holds until it is cleared. A matching slot leaves `lrc_err` low.
- R10: `err_clr` clears `lrc_err` on the next clock edge, unless a mismatching slot strobe occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chr_vld | input | 1 | Character strobe |
| chr_data | input | CHAR_W | Character; MSB is the parity bit |
| dir_tx | input | 1 | 1 = transmit, 0 = receive |
| excl_now | input | 1 | Leave out the current character |
| excl_next | input | 1 | Leave out the next strobed character |
| blk_start | input | 1 | Open a new block |
| chk_next | input | 1 | Current character ends the block; next strobe is the check slot |
| err_clr | input | 1 | Clear the error flag |
| cfg_b8_mode | input | 2 | Top-bit derivation (see R3) |
| cfg_invert | input | 1 | Complement the check character |
| cfg_odd_par | input | 1 | Parity sense for top-bit mode 0 |
| lrc_value | output | CHAR_W | Current check character |
| lrc_slot | output | 1 | Next strobe is the check character |
| sub_vld | output | 1 | Substitute `lrc_value` for the current transmit character |
| lrc_err | output | 1 | Sticky check mismatch |

## Verification
The hardest situation to reach is a slot whose expected value depends on the exclusion history. This happens when a character that is skipped through the deferred flag sits next to one excluded directly, and both sit inside a block opened by a strobe that must itself be dropped. Every block in the sweep is therefore built in one fixed shape: it opens on a strobed character, has one immediate and one deferred exclusion, and ends with a termination character. This shape runs under all sixteen settings of the top-bit mode, complement and parity sense. It runs in transmit, in receive with the correct check character, and in receive with one corrupted bit whose position moves from block to block. The bench rebuilds the expected check character arithmetically from its own model of those rules.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
   typedef enum logic [1:0] {
      B8_SELF_PAR = 2'd0,
      B8_PAR_ACC  = 2'd1,
      B8_ZERO     = 2'd2,
      B8_ONE      = 2'd3
   } b8_mode_e;
endpackage

// File: rtl/lrc_seq.sv
// Tracks deferred exclusion and the pending check slot; decides inclusion.
module lrc_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic chr_vld,
   input  logic blk_start,
   input  logic excl_now,
   input  logic excl_next,
   input  logic chk_next,
   output logic take,
   output logic pend,
   output logic slot_stb
);
   logic skip_q, pend_q;
   logic stb;

   assign stb      = chr_vld & ~blk_start;
   assign slot_stb = stb & pend_q;
   assign take     = stb & ~pend_q & ~skip_q & ~excl_now;
   assign pend     = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         skip_q <= 1'b0;
         pend_q <= 1'b0;
      end else if (blk_start) begin
         skip_q <= 1'b0;
         pend_q <= 1'b0;
      end else if (stb) begin
         skip_q <= excl_next;
         pend_q <= chk_next & ~pend_q;
      end
   end
endmodule

// File: rtl/lrc_accum.sv
// Column-wise XOR of included data bits plus XOR of their parity bits.
module lrc_accum #(
   parameter int CHAR_W = 8,
   localparam int DATA_W = CHAR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take,
   input  logic [CHAR_W-1:0] chr_data,
   output logic [DATA_W-1:0] acc,
   output logic              par_acc
);
   logic [DATA_W-1:0] acc_q;
   logic              par_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         par_q <= 1'b0;
      end else if (clear) begin
         acc_q <= '0;
         par_q <= 1'b0;
      end else if (take) begin
         acc_q <= acc_q ^ chr_data[DATA_W-1:0];
         par_q <= par_q ^ chr_data[CHAR_W-1];
      end
   end

   assign acc     = acc_q;
   assign par_acc = par_q;
endmodule

// File: rtl/lrc_format.sv
// Builds the check character from the accumulator and static settings.
module lrc_format
   import lrc_pkg::*;
#(
   parameter int CHAR_W = 8,
   localparam int DATA_W = CHAR_W - 1
) (
   input  logic [DATA_W-1:0] acc,
   input  logic              par_acc,
   input  logic [1:0]        b8_mode,
   input  logic              invert,
   input  logic              odd_par,
   output logic [CHAR_W-1:0] lrc
);
   logic [DATA_W-1:0] low;
   logic              top;
   b8_mode_e          mode;

   assign mode = b8_mode_e'(b8_mode);

   for (genvar b = 0; b < DATA_W; b++) begin : g_low
      assign low[b] = acc[b] ^ invert;
   end

   always_comb begin
      unique case (mode)
         B8_SELF_PAR: top = (^low) ^ odd_par;
         B8_PAR_ACC:  top = par_acc ^ invert;
         B8_ZERO:     top = 1'b0;
         B8_ONE:      top = 1'b1;
         default:     top = 1'b0;
      endcase
   end

   assign lrc = {top, low};
endmodule

// File: rtl/lrc_check.sv
// Receive-side comparison and sticky error flag.
module lrc_check #(
   parameter int CHAR_W   = 8,
   parameter bit CMP_FULL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_start,
   input  logic              err_clr,
   input  logic              cmp_stb,
   input  logic [CHAR_W-1:0] chr_data,
   input  logic [CHAR_W-1:0] lrc,
   output logic              err
);
   logic [CHAR_W-1:0] mask;
   logic              mism;
   logic              err_q;

   if (CMP_FULL) begin : g_full
      assign mask = '1;
   end else begin : g_data
      assign mask = {1'b0, {(CHAR_W-1){1'b1}}};
   end

   assign mism = cmp_stb & (|((chr_data ^ lrc) & mask));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         err_q <= 1'b0;
      else if (blk_start) err_q <= 1'b0;
      else                err_q <= (err_q & ~err_clr) | mism;
   end

   assign err = err_q;
endmodule

// File: rtl/lrc_engine.sv
module lrc_engine #(
   parameter int CHAR_W   = 8,
   parameter bit CMP_FULL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chr_vld,
   input  logic [CHAR_W-1:0] chr_data,
   input  logic              dir_tx,
   input  logic              excl_now,
   input  logic              excl_next,
   input  logic              blk_start,
   input  logic              chk_next,
   input  logic              err_clr,
   input  logic [1:0]        cfg_b8_mode,
   input  logic              cfg_invert,
   input  logic              cfg_odd_par,
   output logic [CHAR_W-1:0] lrc_value,
   output logic              lrc_slot,
   output logic              sub_vld,
   output logic              lrc_err
);
   localparam int DATA_W = CHAR_W - 1;

   initial begin
      if (CHAR_W < 2) $error("lrc_engine: CHAR_W must be at least 2");
   end

   logic              take, pend, slot_stb;
   logic [DATA_W-1:0] acc;
   logic              par_acc;

   lrc_seq u_seq (
      .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .blk_start(blk_start),
      .excl_now(excl_now), .excl_next(excl_next), .chk_next(chk_next),
      .take(take), .pend(pend), .slot_stb(slot_stb)
   );

   lrc_accum #(.CHAR_W(CHAR_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clear(blk_start), .take(take),
      .chr_data(chr_data), .acc(acc), .par_acc(par_acc)
   );

   lrc_format #(.CHAR_W(CHAR_W)) u_fmt (
      .acc(acc), .par_acc(par_acc), .b8_mode(cfg_b8_mode),
      .invert(cfg_invert), .odd_par(cfg_odd_par), .lrc(lrc_value)
   );

   lrc_check #(.CHAR_W(CHAR_W), .CMP_FULL(CMP_FULL)) u_chk (
      .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .err_clr(err_clr),
      .cmp_stb(slot_stb & ~dir_tx), .chr_data(chr_data), .lrc(lrc_value),
      .err(lrc_err)
   );

   assign lrc_slot = pend;
   assign sub_vld  = slot_stb & dir_tx;
endmodule

// File: rtl/lrc_engine_chk.sv
module lrc_engine_chk #(
   parameter int CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chr_vld,
   input logic              dir_tx,
   input logic              blk_start,
   input logic              chk_next,
   input logic              err_clr,
   input logic [1:0]        cfg_b8_mode,
   input logic              cfg_invert,
   input logic [CHAR_W-1:0] lrc_value,
   input logic              lrc_slot,
   input logic              sub_vld,
   input logic              lrc_err
);
   // R8
   sub_only_tx_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sub_vld |-> (dir_tx && chr_vld && lrc_slot));

   // R4
   start_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_start |=> !lrc_err);

   // R4
   start_clears_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_start |=> (lrc_value[CHAR_W-2:0] == {(CHAR_W-1){cfg_invert}}));

   // R4
   start_clears_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_start |=> !lrc_slot);

   // R3
   top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_b8_mode == 2'd2) |-> !lrc_value[CHAR_W-1]);

   // R3
   top_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_b8_mode == 2'd3) |-> lrc_value[CHAR_W-1]);

   // R9
   err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lrc_err) |-> $past(chr_vld && lrc_slot && !dir_tx));

   // R10
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !chr_vld) |=> !lrc_err);

   // R7
   slot_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_vld && chk_next && !lrc_slot && !blk_start) |=> lrc_slot);

   // R7
   slot_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_vld && lrc_slot && !blk_start) |=> !lrc_slot);
endmodule

bind lrc_engine lrc_engine_chk #(.CHAR_W(CHAR_W)) i_lrc_engine_chk (
   .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .dir_tx(dir_tx),
   .blk_start(blk_start), .chk_next(chk_next), .err_clr(err_clr),
   .cfg_b8_mode(cfg_b8_mode), .cfg_invert(cfg_invert),
   .lrc_value(lrc_value), .lrc_slot(lrc_slot), .sub_vld(sub_vld),
   .lrc_err(lrc_err)
);

// File: tb/test_lrc_engine.sv
module test_lrc_engine;
   localparam int TCLK = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chr_vld = 1'b0;
   logic [7:0] chr_data = '0;
   logic       dir_tx = 1'b0;
   logic       excl_now = 1'b0, excl_next = 1'b0, blk_start = 1'b0;
   logic       chk_next = 1'b0, err_clr = 1'b0;
   logic [1:0] cfg_b8_mode = 2'd0;
   logic       cfg_invert = 1'b0, cfg_odd_par = 1'b0;
   logic [7:0] lrc_value;
   logic       lrc_slot, sub_vld, lrc_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(TCLK/2) clk = ~clk;

   lrc_engine #(.CHAR_W(8), .CMP_FULL(1'b1)) i_lrc_engine (
      .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .chr_data(chr_data),
      .dir_tx(dir_tx), .excl_now(excl_now), .excl_next(excl_next),
      .blk_start(blk_start), .chk_next(chk_next), .err_clr(err_clr),
      .cfg_b8_mode(cfg_b8_mode), .cfg_invert(cfg_invert),
      .cfg_odd_par(cfg_odd_par), .lrc_value(lrc_value),
      .lrc_slot(lrc_slot), .sub_vld(sub_vld), .lrc_err(lrc_err)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_lrc(logic [6:0] a, logic p, logic [1:0] m,
                                          logic inv, logic odd);
      logic [6:0] lo;
      logic       t;
      lo = a ^ {7{inv}};
      case (m)
         2'd0: t = (^lo) ^ odd;
         2'd1: t = p ^ inv;
         2'd2: t = 1'b0;
         default: t = 1'b1;
      endcase
      return {t, lo};
   endfunction

   task automatic put(logic v, logic [7:0] d, logic en, logic xn, logic cn,
                      logic bs, logic ec);
      @(negedge clk);
      chr_vld = v; chr_data = d; excl_now = en; excl_next = xn;
      chk_next = cn; blk_start = bs; err_clr = ec;
      #1;
   endtask

   // kind: 0 transmit, 1 receive with good check, 2 receive with bad check
   task automatic run_block(int cfg, int kind);
      logic [6:0] acc = '0;
      logic       pacc = 1'b0;
      logic       skip = 1'b0;
      logic [7:0] d, e, slot_d;
      logic       m0 = cfg_b8_mode == 2'd0;
      dir_tx = (kind == 0);
      put(1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);  // R4: opening strobe dropped
      for (int i = 0; i < 12; i++) begin
         d = 8'((i * 37 + cfg * 11 + kind * 53 + 5) ^ (i << 5));
         put(1'b1, d, i == 3, i == 5, i == 11, 1'b0, 1'b0);
         if (i == 0) begin
            // R4 accumulator cleared by the block start
            check("R4", lrc_value, exp_lrc('0, 1'b0, cfg_b8_mode, cfg_invert, cfg_odd_par));
            check("R4", {7'd0, lrc_err}, 8'd0);
         end
         if (i == 2) check("R8", {7'd0, sub_vld}, 8'd0);
         if (i == 6) check("R7", {7'd0, lrc_slot}, 8'd0);
         // R5 excl_now, R6 excl_next
         if (!(i == 3) && !skip) begin
            acc  = acc ^ d[6:0];
            pacc = pacc ^ d[7];
         end
         skip = (i == 5);
      end
      e = exp_lrc(acc, pacc, cfg_b8_mode, cfg_invert, cfg_odd_par);
      slot_d = (kind == 0) ? 8'h00 : (kind == 1) ? e : e ^ (8'h01 << (cfg % 8));
      put(1'b1, slot_d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R7", {7'd0, lrc_slot}, 8'd1);
      if (m0) check("R1", lrc_value, e);
      else if (cfg_b8_mode == 2'd1) check("R2", lrc_value, e);
      else check("R3", lrc_value, e);
      check("R8", {7'd0, sub_vld}, {7'd0, kind == 0});
      put(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R7", {7'd0, lrc_slot}, 8'd0);
      check("R9", {7'd0, lrc_err}, {7'd0, kind == 2});
      // R7: the slot character was not accumulated
      check("R7", lrc_value, e);
      if (kind == 2) begin
         put(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
         check("R9", {7'd0, lrc_err}, 8'd1);
         put(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
         put(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
         check("R10", {7'd0, lrc_err}, 8'd0);
      end
   endtask

   initial begin
      #(TCLK * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R4", lrc_value, 8'h00);
      check("R8", {6'd0, sub_vld, lrc_err}, 8'd0);
      for (int c = 0; c < 16; c++) begin
         cfg_b8_mode = 2'(c & 3);
         cfg_invert  = c[2];
         cfg_odd_par = c[3];
         for (int k = 0; k < 3; k++) run_block(c, k);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule